// File: doc/BRIEF.md
# Transition-coded link symbol codec

This block carries 9-bit link symbols across a 9-wire line that signals every bit by whether a wire changes state, not by its level. A symbol is an 8-bit byte plus a flag that says whether the symbol is a data byte or a control symbol. The transmit side keeps the present line state. For each symbol it accepts, it flips exactly the wires whose symbol bit is 1, and one symbol can leave per rising clock edge. The receive side remembers the line state it saw on the previous edge. It XORs that state with the present one to recover the symbol, and it raises a one-cycle strobe for each symbol it recovers.

Flow control works in both directions. A block input from the far end stops the transmitter from taking any new symbol. Recovered symbols go into a local buffer that the host drains through a show-ahead read port. When the buffer's occupancy reaches a programmable high-water mark, the receiver raises its own block output so that the far-end transmitter stops. A line that does not change during a cycle decodes to the all-zero control symbol. That symbol is the idle filler: it is never strobed and never buffered.

Top module: `tlink_codec`

## Requirements
- R1: After reset, `line_out` is all zeros, the receiver's remembered line state is all zeros, `rx_strobe` and `rx_valid` are low, and `rx_blk_out` is low whenever `rx_hwm` is nonzero.
- R2: A symbol on `tx_sym` is accepted on a rising edge where `tx_valid` is high and `far_blk_in` is low. After that edge, `line_out` equals its previous value XOR `tx_sym`. Symbol bit 8 is the data flag (1 = data byte, 0 = control symbol) and drives line wire 8. Bits 7..0 are the byte (bit 7 most significant) and drive wires 7..0.
- R3: While `far_blk_in` is high, `tx_ready` is low and `line_out` does not change, whatever `tx_valid` and `tx_sym` are.
- R4: On an edge where no symbol is accepted, `line_out` does not change. The far end therefore sees the null control symbol (flag 0, byte 0x00).
- R5: On each rising edge, the receiver compares `line_in` with the line state it sampled on the previous edge. If they differ, `rx_strobe` is high for the following cycle and `rx_strobe_sym` holds the bitwise difference, with the same bit layout as R2.
- R6: If `line_in` is unchanged from the previous edge, `rx_strobe` is low for the following cycle and nothing is added to the buffer.
- R7: Each strobed symbol is written to a buffer of `DEPTH` entries on the edge that ends its strobe cycle. `rx_valid` is high while the buffer holds at least one entry, and `rx_sym` shows the oldest entry. An edge with `rx_take` and `rx_valid` both high removes that entry, so symbols leave in the order they arrived.
- R8: `rx_blk_out` is high exactly when the buffer occupancy is greater than or equal to `rx_hwm`.
- R9: A strobed symbol that arrives when the buffer is full and no entry is removed on the same edge is dropped. The buffered entries and their order are unchanged. If an entry is removed on that edge, the new symbol is kept.
- R10: `rx_take` while `rx_valid` is low has no effect on the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_valid | input | 1 | A symbol is offered on `tx_sym` |
| tx_sym | input | 9 | Symbol to send: bit 8 is the data flag, bits 7..0 the byte |
| tx_ready | output | 1 | The transmitter can take a symbol (low while blocked) |
| line_out | output | 9 | Transition-coded transmit line |
| far_blk_in | input | 1 | Far end asks this transmitter to stop |
| line_in | input | 9 | Transition-coded receive line |
| rx_hwm | input | $clog2(DEPTH+1) | Occupancy at which `rx_blk_out` rises |
| rx_blk_out | output | 1 | Asks the far-end transmitter to stop |
| rx_strobe | output | 1 | One-cycle strobe for each recovered symbol |
| rx_strobe_sym | output | 9 | Recovered symbol, valid with `rx_strobe` |
| rx_valid | output | 1 | The buffer holds at least one symbol |
| rx_sym | output | 9 | Oldest buffered symbol |
| rx_take | input | 1 | Remove the oldest buffered symbol |

## Verification
The bench drives the buffer to full while the line keeps toggling every cycle, and it also takes an entry on the same edge that a symbol arrives at a full buffer. A design that refuses the write when a read frees the slot loses symbols, and one that writes without a free slot corrupts the oldest entry. It sends explicit control symbols with nonzero codes and long quiet stretches. A decoder that strobes on level instead of change, or that buffers the idle filler, shows up as extra or wrong entries. It keeps `tx_valid` high while the far end blocks, which exposes a transmitter that toggles wires it should hold. It also sweeps `rx_hwm` across the occupancy range, so an off-by-one in the block threshold shows up at the boundary.

// File: rtl/tlink_pkg.sv
package tlink_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYM_W  = BYTE_W + 1;
  localparam int unsigned FLAG_BIT = BYTE_W;

  typedef struct packed {
    logic              is_data;
    logic [BYTE_W-1:0] payload;
  } tl_sym_t;
endpackage

// File: rtl/tlink_tx_enc.sv
module tlink_tx_enc
  import tlink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  input  logic             far_blk,
  output logic             ready,
  output logic [SYM_W-1:0] line
);
  logic             acc;
  logic [SYM_W-1:0] line_q;
  logic [SYM_W-1:0] line_d;

  always_comb begin
    acc = sym_valid & ~far_blk;
  end

  // one toggle lane per wire
  for (genvar i = 0; i < SYM_W; i++) begin : g_lane
    assign line_d[i] = line_q[i] ^ sym[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (acc) begin
      line_q <= line_d;
    end
  end

  assign ready = ~far_blk;
  assign line  = line_q;

  // R3
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_blk |=> $stable(line_q));

  // R2
  flag_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !far_blk && sym[FLAG_BIT]) |=> (line_q[FLAG_BIT] != $past(line_q[FLAG_BIT])));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(line_q));
endmodule

// File: rtl/tlink_rx_dec.sv
module tlink_rx_dec
  import tlink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] line_in,
  output logic             stb,
  output logic [SYM_W-1:0] stb_sym
);
  logic [SYM_W-1:0] prev_q;
  logic [SYM_W-1:0] diff;
  logic [SYM_W-1:0] sym_q;
  logic             stb_q;
  logic             hit;

  for (genvar i = 0; i < SYM_W; i++) begin : g_lane
    assign diff[i] = line_in[i] ^ prev_q[i];
  end

  always_comb begin
    hit = |diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stb_q  <= 1'b0;
      sym_q  <= '0;
    end else begin
      prev_q <= line_in;
      stb_q  <= hit;
      if (hit) begin
        sym_q <= diff;
      end
    end
  end

  assign stb     = stb_q;
  assign stb_sym = sym_q;

  // R6
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(line_in) |=> !stb_q);

  // R5
  strobe_nonnull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (sym_q != '0));
endmodule

// File: rtl/tlink_rx_buf.sv
module tlink_rx_buf
  import tlink_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             rd_take,
  input  logic [OCC_W-1:0] hwm,
  output logic             rd_valid,
  output logic [SYM_W-1:0] rd_sym,
  output logic             blk
);
  logic [SYM_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             full, pop, push;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full = (occ_q == OCC_W'(DEPTH));
    pop  = rd_take && (occ_q != '0);
    push = wr_en && (!full || pop);
    wr_d = push ? ptr_step(wr_q) : wr_q;
    rd_d = pop  ? ptr_step(rd_q) : rd_q;
    unique case ({push, pop})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else if (push || pop) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_q] <= wr_sym;
    end
  end

  assign rd_valid = (occ_q != '0);
  assign rd_sym   = mem[rd_q];
  assign blk      = (occ_q >= hwm);

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  // R10
  empty_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ_q == '0) && !wr_en) |=> (occ_q == '0));

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ_q == OCC_W'(DEPTH)) && !rd_take) |=> ((occ_q == OCC_W'(DEPTH)) && $stable(wr_q) && $stable(rd_q)));
endmodule

// File: rtl/tlink_codec.sv
module tlink_codec
  import tlink_pkg::*;
#(
  parameter  int unsigned DEPTH       = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned OCC_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic [SYM_W-1:0] tx_sym,
  output logic             tx_ready,
  output logic [SYM_W-1:0] line_out,
  input  logic             far_blk_in,
  input  logic [SYM_W-1:0] line_in,
  input  logic [OCC_W-1:0] rx_hwm,
  output logic             rx_blk_out,
  output logic             rx_strobe,
  output logic [SYM_W-1:0] rx_strobe_sym,
  output logic             rx_valid,
  output logic [SYM_W-1:0] rx_sym,
  input  logic             rx_take
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= SYNC_STAGES'({rst_pipe, 1'b1});
    end
  end

  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  tlink_tx_enc u_tx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sym_valid (tx_valid),
    .sym       (tx_sym),
    .far_blk   (far_blk_in),
    .ready     (tx_ready),
    .line      (line_out)
  );

  tlink_rx_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .line_in (line_in),
    .stb     (rx_strobe),
    .stb_sym (rx_strobe_sym)
  );

  tlink_rx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (rx_strobe),
    .wr_sym   (rx_strobe_sym),
    .rd_take  (rx_take),
    .hwm      (rx_hwm),
    .rd_valid (rx_valid),
    .rd_sym   (rx_sym),
    .blk      (rx_blk_out)
  );
endmodule

// File: tb/tlink_codec_tb.sv
module tlink_codec_tb;
  localparam int DEPTH = 8;
  localparam int SW    = 9;
  localparam int OW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tx_valid;
  logic [SW-1:0] tx_sym;
  logic          tx_ready;
  logic [SW-1:0] line_out;
  logic          far_blk_in;
  logic [SW-1:0] line_in;
  logic [OW-1:0] rx_hwm;
  logic          rx_blk_out;
  logic          rx_strobe;
  logic [SW-1:0] rx_strobe_sym;
  logic          rx_valid;
  logic [SW-1:0] rx_sym;
  logic          rx_take;

  tlink_codec #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_sym(tx_sym), .tx_ready(tx_ready),
    .line_out(line_out), .far_blk_in(far_blk_in), .line_in(line_in), .rx_hwm(rx_hwm),
    .rx_blk_out(rx_blk_out), .rx_strobe(rx_strobe), .rx_strobe_sym(rx_strobe_sym),
    .rx_valid(rx_valid), .rx_sym(rx_sym), .rx_take(rx_take)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // behavioural reference
  bit [SW-1:0] m_line, m_prev, m_ssym;
  bit          m_stb;
  bit [SW-1:0] m_q[$];
  string       t_tag, s_tag, q_tag;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_line = '0; m_prev = '0; m_ssym = '0; m_stb = 0; m_q.delete();
      t_tag = "R1"; s_tag = "R1"; q_tag = "R1";
    end else begin
      bit pop, acc;
      pop = rx_take && (m_q.size() > 0);
      acc = m_stb && ((m_q.size() < DEPTH) || pop);
      if (m_stb && !acc) q_tag = "R9";
      else if (rx_take && m_q.size() == 0) q_tag = "R10";
      else q_tag = "R7";
      if (pop) void'(m_q.pop_front());
      if (acc) m_q.push_back(m_ssym);
      m_stb  = (line_in != m_prev);
      m_ssym = line_in ^ m_prev;
      m_prev = line_in;
      s_tag  = m_stb ? "R5" : "R6";
      if (tx_valid && !far_blk_in) begin
        m_line = m_line ^ tx_sym;
        t_tag  = "R2";
      end else begin
        t_tag = far_blk_in ? "R3" : "R4";
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    chk(line_out === m_line, t_tag, "line_out", 32'(line_out), 32'(m_line));
    chk(tx_ready === !far_blk_in, "R3", "tx_ready", 32'(tx_ready), 32'(!far_blk_in));
    chk(rx_strobe === m_stb, s_tag, "rx_strobe", 32'(rx_strobe), 32'(m_stb));
    if (m_stb) chk(rx_strobe_sym === m_ssym, "R5", "rx_strobe_sym", 32'(rx_strobe_sym), 32'(m_ssym));
    chk(rx_valid === (m_q.size() > 0), q_tag, "rx_valid", 32'(rx_valid), 32'(m_q.size() > 0));
    if (m_q.size() > 0) chk(rx_sym === m_q[0], q_tag, "rx_sym", 32'(rx_sym), 32'(m_q[0]));
    chk(rx_blk_out === (m_q.size() >= int'(rx_hwm)), "R8", "rx_blk_out",
        32'(rx_blk_out), 32'(m_q.size() >= int'(rx_hwm)));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
      finish_run();
    end
  end

  function automatic logic [SW-1:0] rnd_sym(input int data_pct);
    logic [SW-1:0] s;
    s[7:0] = 8'($urandom_range(0, 255));
    s[8]   = ($urandom_range(0, 99) < data_pct);
    return s;
  endfunction

  initial begin
    rst_n = 1'b0; tx_valid = 0; tx_sym = '0; far_blk_in = 0;
    line_in = '0; rx_hwm = OW'(6); rx_take = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(line_out === '0, "R1", "reset line_out", 32'(line_out), 0);
    chk(rx_valid === 1'b0, "R1", "reset rx_valid", 32'(rx_valid), 0);
    chk(rx_strobe === 1'b0, "R1", "reset rx_strobe", 32'(rx_strobe), 0);
    chk(rx_blk_out === 1'b0, "R1", "reset rx_blk_out", 32'(rx_blk_out), 0);
    rst_n = 1'b1;
    repeat (5) begin @(negedge clk); check_all(); end

    // mixed traffic both directions
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); check_all();
      tx_valid   = ($urandom_range(0, 9) < 7);
      tx_sym     = rnd_sym(70);
      far_blk_in = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 1) line_in = line_in ^ rnd_sym(60);
      rx_take    = ($urandom_range(0, 9) < 6);
    end

    // R3: valid held high while blocked
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); check_all();
      tx_valid = 1; tx_sym = rnd_sym(50); far_blk_in = 1;
    end
    far_blk_in = 0; tx_valid = 0;

    // R9: fill past full with no takes, then take on a full arrival
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); check_all();
      line_in = line_in ^ rnd_sym(100);
      rx_take = (i == 30);
    end
    rx_take = 0;

    // R10: drain with no arrivals, takes continue on empty
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); check_all();
      rx_take = 1;
    end

    // R8: sweep the high-water mark; explicit control codes
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); check_all();
      if (i % 25 == 0) rx_hwm = OW'($urandom_range(1, DEPTH));
      tx_valid = ($urandom_range(0, 1) == 1);
      tx_sym   = rnd_sym(30);
      far_blk_in = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 2) != 0) line_in = line_in ^ rnd_sym(30);
      rx_take  = ($urandom_range(0, 9) < 4);
    end
    rx_take = 0; tx_valid = 0;
    repeat (5) begin @(negedge clk); check_all(); end
    finish_run();
  end
endmodule